// File: doc/BRIEF.md
# Status Event Interrupt Controller

This block turns the level status signals of a network transceiver into latched interrupt flags and drives one active-low interrupt line. It watches six status sources: energy detect, remote fault, link up, link-partner acknowledge, parallel detection fault and page received. Each source has its own edge that sets its flag and its own list of events that clear it. A small register port lets software read the flag register, read and write the mask register, and read and write a control register. Two read strobes tell the block that software has read one of the other status registers whose reads also clear flags.

There are two clearing schemes. In the default scheme, flags clear when their source returns to idle, when a status register is read, or when a negotiation restart or link loss occurs. In the alternate scheme, selected by a control bit, none of those events clears a flag. Software instead writes a one to a flag bit. The block then looks at the live source and clears the flag only if the source has gone idle.

Every status input passes through a two-stage synchroniser. Edges are then found by comparing the synchronised level with a registered copy of it. The interrupt line is low whenever at least one flag is set while its mask bit is set.

Top module: `irq_status_ctrl`

## Requirements
- R1: Flag and mask bits share positions: energy detect 7, remote fault 5, link down 4, partner acknowledge 3, parallel detection fault 2, page received 1. Bits 6 and 0 always read 0, so writing 0xFF to the mask reads back 0xBE.
- R2: `irq_n` is 0 exactly when some flag bit and the same mask bit are both 1. The mask resets to 0, so a mask write of 0 releases the line.
- R3: A change on a status input is seen at the third rising clock edge after it, after two synchroniser stages and one edge-detect register. At the second edge the flag is still unchanged.
- R4: The remote fault flag sets when the source rises. In default mode it clears when the source falls, on a `rd_stat_basic` strobe, or on a flag register read.
- R5: The link down flag sets when `stat_link_up` falls. In default mode it clears only on a `rd_stat_basic` strobe or a flag register read.
- R6: The partner acknowledge flag sets when the source rises. In default mode it clears when the source falls or on a flag register read.
- R7: The parallel fault and page received flags each set when their source rises. In default mode each clears when its source falls, on a `rd_stat_expan` strobe, on a flag register read, on an `anneg_restart` pulse, or when the link goes down.
- R8: After reset the energy flag reads 1 and the control register reads 0x02. Control bit 1 shows the live synchronised energy level. The energy flag sets when energy rises and, in default mode, clears when energy falls or on a flag register read.
- R9: `reg_sel` encodes 0 as flag, 1 as mask, 2 as control, and 3 reads 0. Control bit 6 selects alternate mode, resets to 0, and takes effect from the cycle after the write.
- R10: In default mode a write to the flag register changes no flag.
- R11: In alternate mode, reads, strobes, source falls, restarts and link loss clear no flag. Writing 1 to a flag bit clears it only if its source is idle. Idle means the source is low; for link down, it means the link is up.
- R12: When a set event and a clear event hit the same flag in the same cycle, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_energy | input | 1 | Energy detect status level |
| stat_rfault | input | 1 | Remote fault status level |
| stat_link_up | input | 1 | Link up status level |
| stat_lp_ack | input | 1 | Link partner acknowledge status level |
| stat_pd_fault | input | 1 | Parallel detection fault status level |
| stat_page_rx | input | 1 | Page received status level |
| anneg_restart | input | 1 | One-cycle pulse: negotiation restarted |
| rd_stat_basic | input | 1 | One-cycle strobe: basic status register read |
| rd_stat_expan | input | 1 | One-cycle strobe: negotiation expansion register read |
| reg_rd | input | 1 | Read strobe for the register selected by `reg_sel` |
| reg_wr | input | 1 | Write strobe for the register selected by `reg_sel` |
| reg_sel | input | 2 | Register select: 0 flag, 1 mask, 2 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high together. They also assume that every flag change comes from the block's own set, clear and recheck events, with nothing forced from outside. The bench drives all inputs once per cycle, well away from the clock edge. It uses single-cycle strobes and never raises both register strobes at once. It leaves each status level stable for at least three cycles between changes, except when it lines a set edge up with a read on purpose to test the case where a set and a clear meet.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_SRC  = 6;

    localparam int L_PAGE   = 1;
    localparam int L_PDF    = 2;
    localparam int L_ACK    = 3;
    localparam int L_LINK   = 4;
    localparam int L_RFLT   = 5;
    localparam int L_ENERGY = 7;

    localparam int CTRL_ENERGY_BIT = 1;
    localparam int CTRL_ALT_BIT    = 6;

    localparam logic [REG_W-1:0] IMPL_MASK = 8'hBE;
    // Synchronised level and flag value after reset: only energy detect starts high.
    localparam logic [REG_W-1:0] LANE_RST  = 8'h80;

    typedef enum logic [1:0] {
        SEL_FLAG = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] lvl;
        logic [REG_W-1:0] rise;
        logic [REG_W-1:0] fall;
    } src_view_t;

    typedef struct packed {
        logic [REG_W-1:0] set;
        logic [REG_W-1:0] clr;
        logic [REG_W-1:0] idle;
    } evt_t;

    // Source index (port order) to register lane.
    function automatic int lane_of(input int idx);
        case (idx)
            0:       return L_PAGE;
            1:       return L_PDF;
            2:       return L_ACK;
            3:       return L_LINK;
            4:       return L_RFLT;
            default: return L_ENERGY;
        endcase
    endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N                 = 6,
    parameter int STAGES            = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{RST_VAL[i]}};
                prev  <= RST_VAL[i];
            end else begin
                chain <= {chain[STAGES-2:0], din[i]};
                prev  <= chain[STAGES-1];
            end
        end
        assign lvl[i]  = chain[STAGES-1];
        assign rise[i] = chain[STAGES-1] & ~prev;
        assign fall[i] = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/irqc_event_map.sv
module irqc_event_map
    import irqc_pkg::*;
(
    input  src_view_t view,
    input  logic      rd_flags,
    input  logic      rd_stat_basic,
    input  logic      rd_stat_expan,
    input  logic      anneg_restart,
    output evt_t      ev
);
    logic link_lost;

    always_comb begin
        link_lost = view.fall[L_LINK];
        ev        = '0;

        ev.set[L_ENERGY]  = view.rise[L_ENERGY];
        ev.clr[L_ENERGY]  = view.fall[L_ENERGY] | rd_flags;
        ev.idle[L_ENERGY] = ~view.lvl[L_ENERGY];

        ev.set[L_RFLT]    = view.rise[L_RFLT];
        ev.clr[L_RFLT]    = view.fall[L_RFLT] | rd_stat_basic | rd_flags;
        ev.idle[L_RFLT]   = ~view.lvl[L_RFLT];

        ev.set[L_LINK]    = link_lost;
        ev.clr[L_LINK]    = rd_stat_basic | rd_flags;
        ev.idle[L_LINK]   = view.lvl[L_LINK];

        ev.set[L_ACK]     = view.rise[L_ACK];
        ev.clr[L_ACK]     = view.fall[L_ACK] | rd_flags;
        ev.idle[L_ACK]    = ~view.lvl[L_ACK];

        ev.set[L_PDF]     = view.rise[L_PDF];
        ev.clr[L_PDF]     = view.fall[L_PDF] | rd_stat_expan | rd_flags
                          | anneg_restart | link_lost;
        ev.idle[L_PDF]    = ~view.lvl[L_PDF];

        ev.set[L_PAGE]    = view.rise[L_PAGE];
        ev.clr[L_PAGE]    = view.fall[L_PAGE] | rd_stat_expan | rd_flags
                          | anneg_restart | link_lost;
        ev.idle[L_PAGE]   = ~view.lvl[L_PAGE];
    end
endmodule

// File: rtl/irqc_flag_cell.sv
module irqc_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic alt_mode,
    input  logic recheck,
    input  logic idle,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= RST_VAL;
        end else if (set_ev) begin
            flag <= 1'b1;                 // a set never loses to a clear
        end else if (!alt_mode && clr_ev) begin
            flag <= 1'b0;
        end else if (alt_mode && recheck && idle) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stat_energy,
    input  logic             stat_rfault,
    input  logic             stat_link_up,
    input  logic             stat_lp_ack,
    input  logic             stat_pd_fault,
    input  logic             stat_page_rx,
    input  logic             anneg_restart,
    input  logic             rd_stat_basic,
    input  logic             rd_stat_expan,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_n
);
    localparam logic [NUM_SRC-1:0] SRC_RST = LANE_RST[L_ENERGY] << (NUM_SRC-1);

    logic [NUM_SRC-1:0] src_in, s_lvl, s_rise, s_fall;
    src_view_t          view;
    evt_t               ev;
    logic [REG_W-1:0]   flag_q, mask_q, recheck_vec;
    logic               alt_q, rd_flags;
    reg_sel_e           sel;

    assign sel    = reg_sel_e'(reg_sel);
    assign src_in = {stat_energy, stat_rfault, stat_link_up,
                     stat_lp_ack, stat_pd_fault, stat_page_rx};

    irqc_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES), .RST_VAL(SRC_RST)) u_sync (
        .clk(clk), .rst(rst), .din(src_in),
        .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
    );

    always_comb begin
        view = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            view.lvl[lane_of(i)]  = s_lvl[i];
            view.rise[lane_of(i)] = s_rise[i];
            view.fall[lane_of(i)] = s_fall[i];
        end
    end

    assign rd_flags = reg_rd && (sel == SEL_FLAG);

    irqc_event_map u_map (
        .view(view), .rd_flags(rd_flags), .rd_stat_basic(rd_stat_basic),
        .rd_stat_expan(rd_stat_expan), .anneg_restart(anneg_restart), .ev(ev)
    );

    assign recheck_vec = (reg_wr && sel == SEL_FLAG && alt_q) ? reg_wdata : '0;

    for (genvar l = 0; l < REG_W; l++) begin : g_lane
        if (IMPL_MASK[l]) begin : g_impl
            irqc_flag_cell #(.RST_VAL(LANE_RST[l])) u_cell (
                .clk(clk), .rst(rst), .set_ev(ev.set[l]), .clr_ev(ev.clr[l]),
                .alt_mode(alt_q), .recheck(recheck_vec[l]), .idle(ev.idle[l]),
                .flag(flag_q[l])
            );
        end else begin : g_none
            assign flag_q[l] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            alt_q  <= 1'b0;
        end else if (reg_wr) begin
            if (sel == SEL_MASK) mask_q <= reg_wdata & IMPL_MASK;
            if (sel == SEL_CTRL) alt_q  <= reg_wdata[CTRL_ALT_BIT];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_FLAG: reg_rdata = flag_q;
            SEL_MASK: reg_rdata = mask_q;
            SEL_CTRL: begin
                reg_rdata[CTRL_ALT_BIT]    = alt_q;
                reg_rdata[CTRL_ENERGY_BIT] = view.lvl[L_ENERGY];
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_n = ~|(flag_q & mask_q);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq_n,
    input logic [REG_W-1:0] flag_q,
    input logic [REG_W-1:0] mask_q,
    input logic             alt_q,
    input logic [REG_W-1:0] set_vec,
    input logic [REG_W-1:0] recheck_vec,
    input logic             reg_wr,
    input logic [1:0]       reg_sel,
    input logic [REG_W-1:0] reg_wdata
);
    assert_unused_lanes_R1: assert property (@(posedge clk) disable iff (rst)
        ((flag_q | mask_q) & ~IMPL_MASK) == '0);

    assert_irq_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> |(flag_q & mask_q));

    assert_rise_needs_set_R3: assert property (@(posedge clk) disable iff (rst)
        (set_vec == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

    assert_alt_write_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd2) |=> (alt_q == $past(reg_wdata[CTRL_ALT_BIT])));

    assert_alt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (alt_q && recheck_vec == '0) |=> ((~flag_q & $past(flag_q)) == '0));

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));
endmodule

bind irq_status_ctrl irqc_checker u_chk (
    .clk(clk), .rst(rst), .irq_n(irq_n), .flag_q(flag_q), .mask_q(mask_q),
    .alt_q(alt_q), .set_vec(ev.set), .recheck_vec(recheck_vec),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stat_energy = 1'b1, stat_rfault = 1'b0, stat_link_up = 1'b0;
    logic stat_lp_ack = 1'b0, stat_pd_fault = 1'b0, stat_page_rx = 1'b0;
    logic anneg_restart = 1'b0, rd_stat_basic = 1'b0, rd_stat_expan = 1'b0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int    n_vec  = 0;
    int    n_fail = 0;
    string tag    = "R8";

    // reference state: synchroniser pipes per lane, flags, mask, mode
    bit [7:0] m_s1, m_s2, m_pv, m_flag, m_mask;
    bit       m_alt;

    always #4 clk = ~clk;

    irq_status_ctrl u0 (
        .clk(clk), .rst(rst), .stat_energy(stat_energy), .stat_rfault(stat_rfault),
        .stat_link_up(stat_link_up), .stat_lp_ack(stat_lp_ack),
        .stat_pd_fault(stat_pd_fault), .stat_page_rx(stat_page_rx),
        .anneg_restart(anneg_restart), .rd_stat_basic(rd_stat_basic),
        .rd_stat_expan(rd_stat_expan), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", t, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] m_read(input bit [1:0] s);
        case (s)
            2'd0:    return m_flag;
            2'd1:    return m_mask;
            2'd2:    return {1'b0, m_alt, 4'b0, m_s2[7], 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_edge();
        bit [7:0] live, rise, fall, set, clr, idle, nf;
        bit rdf;
        live = {stat_energy, 1'b0, stat_rfault, stat_link_up,
                stat_lp_ack, stat_pd_fault, stat_page_rx, 1'b0};
        if (rst) begin
            m_s1 = 8'h80; m_s2 = 8'h80; m_pv = 8'h80;
            m_flag = 8'h80; m_mask = 8'h00; m_alt = 1'b0;
            return;
        end
        rise = m_s2 & ~m_pv;
        fall = ~m_s2 & m_pv;
        rdf  = reg_rd && reg_sel == 2'd0;
        set  = {rise[7], 1'b0, rise[5], fall[4], rise[3], rise[2], rise[1], 1'b0};
        clr  = 8'h00;
        clr[7] = fall[7] | rdf;
        clr[5] = fall[5] | rd_stat_basic | rdf;
        clr[4] = rd_stat_basic | rdf;
        clr[3] = fall[3] | rdf;
        clr[2] = fall[2] | rd_stat_expan | rdf | anneg_restart | fall[4];
        clr[1] = fall[1] | rd_stat_expan | rdf | anneg_restart | fall[4];
        idle = ~m_s2;
        idle[4] = m_s2[4];
        nf = m_flag;
        foreach (nf[b]) begin
            if (set[b]) nf[b] = 1'b1;
            else if (!m_alt && clr[b]) nf[b] = 1'b0;
            else if (m_alt && reg_wr && reg_sel == 2'd0 && reg_wdata[b] && idle[b]) nf[b] = 1'b0;
        end
        m_flag = nf & 8'hBE;
        if (reg_wr && reg_sel == 2'd1) m_mask = reg_wdata & 8'hBE;
        if (reg_wr && reg_sel == 2'd2) m_alt = reg_wdata[6];
        m_pv = m_s2; m_s2 = m_s1; m_s1 = live;
    endtask

    // one clock: advance model at the edge, compare shortly after
    task automatic cyc();
        @(posedge clk);
        model_edge();
        #2;
        chk({7'd0, irq_n}, {7'd0, ~|(m_flag & m_mask)}, {tag, " irq_n"});
        chk(reg_rdata, m_read(reg_sel), {tag, " rdata"});
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic peek(input bit [1:0] s, input logic [7:0] exp, input string t);
        reg_sel = s;
        #1;
        chk(reg_rdata, exp, t);
    endtask

    task automatic write_reg(input bit [1:0] s, input logic [7:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input bit [1:0] s);
        reg_sel = s; reg_rd = 1'b1;
        cyc();
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(3);

        tag = "R8";
        peek(2'd0, 8'h80, "R8 energy flag after reset");
        peek(2'd2, 8'h02, "R8 control after reset");
        peek(2'd3, 8'h00, "R9 unused select");
        chk({7'd0, irq_n}, 8'h01, "R2 idle line with mask clear");

        tag = "R1";
        write_reg(2'd1, 8'hFF);
        peek(2'd1, 8'hBE, "R1 mask implemented bits");
        chk({7'd0, irq_n}, 8'h00, "R2 energy flag unmasked");

        tag = "R10";
        write_reg(2'd0, 8'hFF);
        peek(2'd0, 8'h80, "R10 default-mode flag write ignored");

        tag = "R8";
        read_reg(2'd0);
        peek(2'd0, 8'h00, "R8 flag read clears energy");
        chk({7'd0, irq_n}, 8'h01, "R2 released after clear");

        tag = "R3";
        stat_energy = 1'b0; wait_cyc(4);
        stat_energy = 1'b1;
        wait_cyc(2);
        peek(2'd0, 8'h00, "R3 not yet set after two edges");
        wait_cyc(1);
        peek(2'd0, 8'h80, "R3 set on third edge");
        tag = "R8";
        stat_energy = 1'b0; wait_cyc(3);
        peek(2'd0, 8'h00, "R8 energy fall clears");
        peek(2'd2, 8'h00, "R8 live energy low");

        tag = "R4";
        stat_rfault = 1'b1; wait_cyc(3);
        peek(2'd0, 8'h20, "R4 remote fault set");
        rd_stat_basic = 1'b1; cyc(); rd_stat_basic = 1'b0;
        peek(2'd0, 8'h00, "R4 basic status read clears");
        stat_rfault = 1'b0; wait_cyc(3);
        stat_rfault = 1'b1; wait_cyc(3);
        stat_rfault = 1'b0; wait_cyc(3);
        peek(2'd0, 8'h00, "R4 fall clears");

        tag = "R5";
        stat_link_up = 1'b1; wait_cyc(3);
        peek(2'd0, 8'h00, "R5 link rise no flag");
        stat_link_up = 1'b0; wait_cyc(5);
        peek(2'd0, 8'h10, "R5 link down held");
        rd_stat_basic = 1'b1; cyc(); rd_stat_basic = 1'b0;
        peek(2'd0, 8'h00, "R5 basic status read clears");

        tag = "R6";
        stat_lp_ack = 1'b1; wait_cyc(3);
        peek(2'd0, 8'h08, "R6 ack set");
        stat_lp_ack = 1'b0; wait_cyc(3);
        peek(2'd0, 8'h00, "R6 ack fall clears");

        tag = "R7";
        stat_pd_fault = 1'b1; stat_page_rx = 1'b1; wait_cyc(3);
        peek(2'd0, 8'h06, "R7 fault and page set");
        anneg_restart = 1'b1; cyc(); anneg_restart = 1'b0;
        peek(2'd0, 8'h00, "R7 restart clears");
        stat_pd_fault = 1'b0; stat_page_rx = 1'b0; wait_cyc(3);
        stat_pd_fault = 1'b1; stat_page_rx = 1'b1; wait_cyc(3);
        rd_stat_expan = 1'b1; cyc(); rd_stat_expan = 1'b0;
        peek(2'd0, 8'h00, "R7 expansion read clears");
        stat_pd_fault = 1'b0; stat_page_rx = 1'b0; wait_cyc(3);
        stat_link_up = 1'b1; wait_cyc(3);
        stat_pd_fault = 1'b1; stat_page_rx = 1'b1; wait_cyc(3);
        stat_link_up = 1'b0; wait_cyc(3);
        peek(2'd0, 8'h10, "R7 link loss clears fault and page");
        read_reg(2'd0);
        stat_pd_fault = 1'b0; stat_page_rx = 1'b0; wait_cyc(3);

        tag = "R12";
        stat_rfault = 1'b1; wait_cyc(2);
        read_reg(2'd0);
        peek(2'd0, 8'h20, "R12 set wins over read clear");
        stat_rfault = 1'b0; wait_cyc(3);

        tag = "R9";
        write_reg(2'd2, 8'h40);
        peek(2'd2, 8'h40, "R9 alternate mode bit");

        tag = "R11";
        stat_pd_fault = 1'b1; wait_cyc(3);
        read_reg(2'd0);
        peek(2'd0, 8'h04, "R11 read does not clear");
        rd_stat_expan = 1'b1; cyc(); rd_stat_expan = 1'b0;
        write_reg(2'd0, 8'h04);
        peek(2'd0, 8'h04, "R11 recheck with busy source keeps flag");
        chk({7'd0, irq_n}, 8'h00, "R11 line stays low");
        stat_pd_fault = 1'b0; wait_cyc(3);
        peek(2'd0, 8'h04, "R11 fall does not clear");
        write_reg(2'd0, 8'h04);
        peek(2'd0, 8'h00, "R11 recheck with idle source clears");
        chk({7'd0, irq_n}, 8'h01, "R11 line released");

        tag = "R2";
        stat_pd_fault = 1'b1; wait_cyc(3);
        chk({7'd0, irq_n}, 8'h00, "R2 asserted by fault");
        write_reg(2'd1, 8'h00);
        chk({7'd0, irq_n}, 8'h01, "R2 mask clear releases line");
        wait_cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule